// File: doc/BRIEF.md
# ADC Result Serializer

This block takes 12-bit conversion results from an ADC and sends them one bit per serial-clock cycle on a single data line, most significant bit first. The serial clock is the block's own clock. A slower sample clock, sampled on that serial clock, marks the frame boundaries. Each low-to-high transition of the sample clock opens a new frame. The block takes one result at that point and starts shifting it out. Output bits change on the rising edge of the serial clock, so the host can capture them on the falling edge with the full half period as setup and hold margin.

A rate input picks the frame length. At the lower sample rates, one sample period spans 32 serial-clock periods. At the higher rates it spans 16. Only the first 12 slots of each frame carry data. The line stays low for the remaining slots and whenever no frame is running. A frame, once started, runs to its last slot. A sample-clock edge that arrives earlier is ignored, so a new conversion can never cut into a word that is still being sent.

Results arrive on a valid/ready interface. `res_ready` rises for exactly one serial-clock cycle, in the cycle where a new frame is accepted. A transfer happens when `res_valid` and `res_ready` are both high in that cycle. The producer holds `res_data` and `res_valid` until it sees `res_ready`. There is no stall on the output side: if `res_valid` is low when a frame opens, the frame is sent as all zeros and no result is consumed.

Top module: `adc_ser_tx`

## Requirements
- R1: After reset, `sdo` is low and `res_ready` stays low while `smp_clk` is low.
- R2: A low-to-high change of `smp_clk`, seen at a `clk` rising edge while no frame is running, is accepted. `res_ready` is high in that cycle, and `sdo` carries result bit 11 after that same edge.
- R3: The accepted result goes out MSB first. Bit 11-k appears on `sdo` in frame slot k, for k = 0 to 11, with one slot per `clk` cycle and each change on the rising edge.
- R4: `sdo` is low in every slot from 12 to the end of the frame, and low while no frame is running.
- R5: With `rate_hi` = 0 a frame lasts 32 slots. A `smp_clk` rising edge in slots 0 to 30 is ignored: `res_ready` stays low and the frame in flight goes out unchanged.
- R6: With `rate_hi` = 1 a frame lasts 16 slots, and an edge in slots 0 to 14 is ignored. `rate_hi` is sampled when a frame is accepted, and a change during the frame has no effect on that frame.
- R7: If `res_valid` is low when a frame is accepted, the frame is sent as all zeros and `res_data` is ignored.
- R8: A `smp_clk` rising edge seen in the last slot of a frame is accepted, and the next frame's slot 0 follows with no gap.
- R9: If `smp_clk` is already high when reset is released, no frame starts. A frame needs a later low-to-high change.
- R10: `res_ready` is high for at most one cycle per `smp_clk` rising edge, and only in a cycle that accepts a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; output bits change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_hi | input | 1 | Frame length select: 0 gives 32 slots, 1 gives 16 slots |
| smp_clk | input | 1 | ADC sample clock; a rising edge marks a frame start |
| res_valid | input | 1 | A conversion result is offered |
| res_ready | output | 1 | One-cycle pulse when a frame is accepted |
| res_data | input | W (12) | Conversion result, bit 11 sent first |
| sdo | output | 1 | Serial data out |

## Verification
The bench builds the block with its default values: 12-bit words and frame lengths of 32 and 16 slots. Both frame lengths are therefore reached within a few hundred cycles. Back-to-back frames are run in which the mode changes at every boundary, so the per-frame latching of the mode and the acceptance in the last slot are exercised for both lengths. Early sample edges are injected in the middle of frames of both lengths, and in the same cycle the mode input is flipped. Each such frame must come out unchanged.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

  typedef enum logic {
    RATE_LO = 1'b0,
    RATE_HI = 1'b1
  } rate_e;

  // Number of bits needed to index every slot of the longer frame
  function automatic int slot_bits(input int frame_lo, input int frame_hi);
    int longest;
    longest = (frame_lo > frame_hi) ? frame_lo : frame_hi;
    return (longest < 2) ? 1 : $clog2(longest);
  endfunction

endpackage

// File: rtl/adc_ser_edge.sv
// Detects a low-to-high change of a level sampled on clk.
// The history flop resets high, so a level that is already high at reset
// release is not taken as an edge.
module adc_ser_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);

  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/adc_ser_slot.sv
// Frame slot tracker. It decides whether a start request is accepted,
// latches the frame length mode and counts slots until the last one.
module adc_ser_slot
  import adc_ser_pkg::*;
#(
  parameter int FRAME_LO = 32,
  parameter int FRAME_HI = 16,
  parameter int SW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          rate_hi,
  output logic          accept,
  output logic          busy,
  output logic [SW-1:0] slot
);

  localparam logic [SW-1:0] LAST_LO = SW'(FRAME_LO - 1);
  localparam logic [SW-1:0] LAST_HI = SW'(FRAME_HI - 1);

  rate_e         mode_q;
  logic [SW-1:0] last_slot;
  logic          at_last;

  assign last_slot = (mode_q == RATE_HI) ? LAST_HI : LAST_LO;
  assign at_last   = (slot == last_slot);
  assign accept    = start_req & (~busy | at_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      slot   <= '0;
      mode_q <= RATE_LO;
    end else if (accept) begin
      busy   <= 1'b1;
      slot   <= '0;
      mode_q <= rate_hi ? RATE_HI : RATE_LO;
    end else if (busy) begin
      if (at_last) busy <= 1'b0;
      else         slot <= slot + 1'b1;
    end
  end

endmodule

// File: rtl/adc_ser_shift.sv
// Parallel-load shifter. Bit W-1 goes straight to the output flop on load.
// Zeros fill in from the bottom, so the line falls low once the word is out.
module adc_ser_shift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         sout
);

  localparam int RW = W - 1;

  logic [RW-1:0] rest_q;

  generate
    if (RW >= 2) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sout   <= 1'b0;
          rest_q <= '0;
        end else if (load) begin
          sout   <= din[W-1];
          rest_q <= din[RW-1:0];
        end else begin
          sout   <= rest_q[RW-1];
          rest_q <= {rest_q[RW-2:0], 1'b0};
        end
      end
    end else begin : g_narrow
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sout   <= 1'b0;
          rest_q <= '0;
        end else if (load) begin
          sout   <= din[W-1];
          rest_q <= din[RW-1:0];
        end else begin
          sout   <= rest_q[RW-1];
          rest_q <= '0;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/adc_ser_tx.sv
module adc_ser_tx
  import adc_ser_pkg::*;
#(
  parameter int W        = 12,
  parameter int FRAME_LO = 32,
  parameter int FRAME_HI = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rate_hi,
  input  logic         smp_clk,
  input  logic         res_valid,
  output logic         res_ready,
  input  logic [W-1:0] res_data,
  output logic         sdo
);

  localparam int SW = slot_bits(FRAME_LO, FRAME_HI);

  logic          smp_rise;
  logic          frm_accept;
  logic          frm_busy;
  logic [SW-1:0] frm_slot;
  logic [W-1:0]  load_word;

  adc_ser_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (smp_clk),
    .rise (smp_rise)
  );

  adc_ser_slot #(
    .FRAME_LO(FRAME_LO),
    .FRAME_HI(FRAME_HI),
    .SW      (SW)
  ) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_req(smp_rise),
    .rate_hi  (rate_hi),
    .accept   (frm_accept),
    .busy     (frm_busy),
    .slot     (frm_slot)
  );

  assign load_word = res_valid ? res_data : '0;
  assign res_ready = frm_accept;

  adc_ser_shift #(
    .W(W)
  ) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .load (frm_accept),
    .din  (load_word),
    .sout (sdo)
  );

endmodule

// File: rtl/adc_ser_tx_chk.sv
module adc_ser_tx_chk #(
  parameter int W        = 12,
  parameter int FRAME_LO = 32,
  parameter int FRAME_HI = 16,
  parameter int SW       = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rate_hi,
  input logic          smp_clk,
  input logic          res_valid,
  input logic          res_ready,
  input logic [W-1:0]  res_data,
  input logic          sdo,
  input logic          frm_busy,
  input logic [SW-1:0] frm_slot
);

  localparam int GW = $clog2(FRAME_LO + 1) + 1;

  // Cycles since the last accepted frame and the length that frame claimed
  logic [GW-1:0] gap_q;
  logic [GW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= GW'(FRAME_LO);
      len_q <= GW'(FRAME_HI);
    end else if (res_ready) begin
      gap_q <= GW'(1);
      len_q <= rate_hi ? GW'(FRAME_HI) : GW'(FRAME_LO);
    end else if (gap_q < GW'(FRAME_LO)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready && res_valid |=> sdo == $past(res_data[W-1])); // R3

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_busy || frm_slot >= SW'(W)) |-> !sdo); // R4

  AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> gap_q >= len_q); // R5

  AST_ZERO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready && !res_valid |=> !sdo); // R7

  AST_READY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> smp_clk && !$past(smp_clk)); // R9

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |=> !res_ready); // R10

endmodule

bind adc_ser_tx adc_ser_tx_chk #(
  .W       (W),
  .FRAME_LO(FRAME_LO),
  .FRAME_HI(FRAME_HI),
  .SW      (SW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rate_hi  (rate_hi),
  .smp_clk  (smp_clk),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .res_data (res_data),
  .sdo      (sdo),
  .frm_busy (frm_busy),
  .frm_slot (frm_slot)
);

// File: tb/adc_ser_tx_bench.sv
`timescale 1ns/1ps
module adc_ser_tx_bench;

  localparam int W   = 12;
  localparam int NLO = 32;
  localparam int NHI = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rate_hi = 1'b0;
  logic         smp_clk = 1'b0;
  logic         res_valid = 1'b0;
  logic         res_ready;
  logic [W-1:0] res_data = '0;
  logic         sdo;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  adc_ser_tx u_adc_ser_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_hi  (rate_hi),
    .smp_clk  (smp_clk),
    .res_valid(res_valid),
    .res_ready(res_ready),
    .res_data (res_data),
    .sdo      (sdo)
  );

  // Vector fields: {rate_hi, res_valid, res_data}
  localparam logic [13:0] VEC [8] = '{
    {1'b0, 1'b1, 12'hA5C},
    {1'b0, 1'b1, 12'hFFF},
    {1'b1, 1'b1, 12'h801},
    {1'b1, 1'b1, 12'h001},
    {1'b0, 1'b0, 12'h7FF},
    {1'b1, 1'b1, 12'h3C6},
    {1'b0, 1'b1, 12'h800},
    {1'b1, 1'b0, 12'hFFF}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge. Starts one frame and captures all its slots.
  // glitch >= 0 injects an early sample edge (with a mode flip) after that slot.
  task automatic run_frame(input bit r, input bit v, input logic [W-1:0] d,
                           input int glitch);
    int          n;
    logic [31:0] got;
    logic [31:0] exp;
    n   = r ? NHI : NLO;
    got = '0;
    exp = '0;
    for (int k = 0; k < W; k++) exp[k] = v & d[W-1-k];
    rate_hi   = r;
    res_valid = v;
    res_data  = d;
    smp_clk   = 1'b1;
    #1;
    check(res_ready == 1'b1, "R2/R8 ready on frame start", 32'(res_ready), 32'd1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      got[k] = sdo;
      if (k == glitch) begin
        smp_clk   = 1'b1;
        res_valid = 1'b1;
        res_data  = ~d;
        rate_hi   = ~r;
        #1;
        check(res_ready == 1'b0, r ? "R6 early edge ignored" : "R5 early edge ignored",
              32'(res_ready), 32'd0);
      end else begin
        smp_clk   = 1'b0;
        res_valid = 1'b0;
        res_data  = '0;
      end
    end
    check(got == exp, "R3/R4/R7 frame bits", got, exp);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sdo == 1'b0, "R1 sdo low after reset", 32'(sdo), 32'd0);
    check(res_ready == 1'b0, "R1 ready low after reset", 32'(res_ready), 32'd0);

    // Table walk: frames back to back, mode changing at boundaries (R8)
    for (int i = 0; i < 8; i++) begin
      run_frame(VEC[i][13], VEC[i][12], VEC[i][11:0], -1);
    end

    // R4: idle line stays low with no sample edge
    begin
      logic [7:0] idle_bits;
      idle_bits = '0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        idle_bits[k] = sdo;
      end
      check(idle_bits == 8'h00, "R4 idle low", 32'(idle_bits), 32'd0);
    end

    // R5: early edge in a 32-slot frame
    run_frame(1'b0, 1'b1, 12'hB37, 5);
    // R6: early edge in a 16-slot frame, mode flipped mid-frame
    run_frame(1'b1, 1'b1, 12'h6D2, 12);
    // R5: early edge in the second-to-last slot of a 32-slot frame
    run_frame(1'b0, 1'b1, 12'h5A5, NLO - 2);

    // R9: sample clock high across reset release
    @(negedge clk);
    rst_n   = 1'b0;
    smp_clk = 1'b1;
    res_valid = 1'b1;
    res_data  = 12'hFFF;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    begin
      logic [3:0] rdy_seen;
      logic [3:0] sdo_seen;
      for (int k = 0; k < 4; k++) begin
        #1;
        rdy_seen[k] = res_ready;
        @(negedge clk);
        sdo_seen[k] = sdo;
      end
      check(rdy_seen == 4'h0, "R9 no start on held level", 32'(rdy_seen), 32'd0);
      check(sdo_seen == 4'h0, "R9 line low on held level", 32'(sdo_seen), 32'd0);
    end
    smp_clk   = 1'b0;
    res_valid = 1'b0;
    @(negedge clk);
    run_frame(1'b1, 1'b1, 12'hC0F, -1);

    // R10: one ready pulse for a long sample-clock high phase
    begin
      int pulses;
      pulses    = 0;
      rate_hi   = 1'b1;
      res_valid = 1'b1;
      res_data  = 12'h123;
      smp_clk   = 1'b1;
      for (int k = 0; k < 6; k++) begin
        #1;
        if (res_ready) pulses++;
        @(negedge clk);
      end
      smp_clk   = 1'b0;
      res_valid = 1'b0;
      check(pulses == 1, "R10 single ready pulse", 32'(pulses), 32'd1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule